// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block collects up to eight interrupt requests and ranks them by a fixed priority, with input 0 the most urgent. It raises a single interrupt line to a processor and answers a one-cycle acknowledge strobe with an 8-bit vector number. The host reaches the block through two byte-wide addresses, a command address and a data address. A software driver first sends a short, ordered setup sequence. That sequence gives the vector base, a cascade word that is only stored and shown on an output, and a mode word. After setup, the driver writes interrupt masks to the data address. On the command address it ends service of one input at a time, or chooses which internal register a command-address read returns.

An acknowledged input is marked in service, and inputs of the same or lower urgency stay blocked until the host ends that service. An optional automatic mode skips this marking. A strobe that finds nothing eligible returns the lowest-priority vector and changes no state. This covers a request that vanished before the strobe arrived.

Top module: `vic8_ctrl`

## Requirements
- R1: After reset the block is unprogrammed, every mask bit is 1, the request and in-service registers are 0, command-address reads return the request register, `int_out` is 0 and `casc_word` is 0.
- R2: A command write of 0x11 starts setup, which clears the request and in-service registers, sets every mask bit and selects request reads. The next three data writes are taken in order as vector base, cascade word and mode word. `int_out` stays 0 until the third write is done, and data writes made before the first 0x11 change nothing.
- R3: With the mode word's bit 1 clear, an acknowledge while `int_out` is 1 returns base plus the index of the winning input on `vec_out` after the strobe's clock edge. It also clears that input's request bit and sets its in-service bit.
- R4: Priority is fixed, with a lower index more urgent. `int_out` is 1 only when an unmasked request exists and no in-service bit is set at an index equal to or below the winning request.
- R5: After setup, a data write loads the mask register, and a mask bit of 1 blocks its input. A data-address read returns the mask.
- R6: The command word 0x0A makes command-address reads return the request register, and 0x0B makes them return the in-service register. The choice holds until the next such command.
- R7: The command word 0x60+n (n from 0 to 7) clears in-service bit n only.
- R8: With mode word bit 1 set, an acknowledge still returns the vector and clears the request bit, but it leaves the in-service register unchanged.
- R9: An acknowledge that finds no eligible request returns base plus 7 and leaves the in-service register unchanged, even when input 7 is masked.
- R10: A request bit is set by a rising edge on its input and is dropped when the input goes low before acknowledge. An input held high after acknowledge raises no new request.
- R11: After setup, `casc_word` shows the stored cascade word.
- R12: If an acknowledge and an end-of-service command land in the same cycle, the command clears its bit and the acknowledge sets its own bit. When both name the same input, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Address select: 0 command, 1 data |
| bus_wr | input | 1 | Write strobe for `bus_wdata` |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the selected address |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt to the processor |
| ack_stb | input | 1 | One-cycle acknowledge strobe |
| vec_out | output | 8 | Vector of the last acknowledge |
| casc_word | output | 8 | Stored cascade configuration word |

## Verification
An acknowledge and an end-of-service command can land in the same clock cycle. Both update the in-service register, one by setting a bit and one by clearing a bit. The bench provokes this by raising the strobe in the same cycle as a command write of 0x60+n. It does this once with n naming an input that is already in service and a different input being acknowledged, and once with n equal to the input being acknowledged. It judges the outcome by reading back the in-service register through the command address. The first case must show only the new bit set. The second case must show the acknowledged bit still set.

// File: rtl/vic8_pkg.sv
package vic8_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BASE,
        PH_CASC,
        PH_MODE,
        PH_RUN
    } phase_e;

    localparam logic [7:0] CMD_SETUP    = 8'h11;
    localparam logic [7:0] CMD_SEL_REQ  = 8'h0A;
    localparam logic [7:0] CMD_SEL_SVC  = 8'h0B;
    localparam logic [4:0] CMD_EOI_TOP  = 5'b01100;
    localparam int         MODE_AUTO_B  = 1;

endpackage

// File: rtl/vic8_edge.sv
module vic8_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end

endmodule

// File: rtl/vic8_prio.sv
module vic8_prio #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vic8_ctrl.sv
module vic8_ctrl
    import vic8_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic              int_out,
    input  logic              ack_stb,
    output logic [7:0]        vec_out,
    output logic [7:0]        casc_word
);
    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
    localparam logic [7:0] LOW_OFS = 8'(NUM_IN - 1);

    typedef struct packed {
        phase_e            phase;
        logic [7:0]        base;
        logic [7:0]        casc;
        logic              aeoi;
        logic              rd_svc;
        logic [NUM_IN-1:0] mask;
        logic [NUM_IN-1:0] irr;
        logic [NUM_IN-1:0] isr;
        logic [7:0]        vec;
    } regs_t;

    regs_t st_q, st_d;

    logic [NUM_IN-1:0] rise;
    logic              req_hit, svc_hit;
    logic [IDX_W-1:0]  req_idx, svc_idx;
    logic              ready, grant;
    logic              cmd_wr, dat_wr, eoi_wr;
    logic [NUM_IN-1:0] ack_one, eoi_one;

    vic8_edge #(.N(NUM_IN)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (irq_in),
        .rise (rise)
    );

    vic8_prio #(.N(NUM_IN), .IW(IDX_W)) u_req_pick (
        .req(st_q.irr & ~st_q.mask),
        .hit(req_hit),
        .idx(req_idx)
    );

    vic8_prio #(.N(NUM_IN), .IW(IDX_W)) u_svc_pick (
        .req(st_q.isr),
        .hit(svc_hit),
        .idx(svc_idx)
    );

    assign ready  = (st_q.phase == PH_RUN);
    assign grant  = ready && req_hit && (!svc_hit || (req_idx < svc_idx));
    assign cmd_wr = bus_wr && !bus_sel;
    assign dat_wr = bus_wr && bus_sel;
    assign eoi_wr = cmd_wr && ready && (bus_wdata[7:3] == CMD_EOI_TOP)
                    && (int'(bus_wdata[2:0]) < NUM_IN);

    always_comb begin
        st_d    = st_q;
        ack_one = '0;
        eoi_one = '0;

        if (eoi_wr) eoi_one = NUM_IN'(1) << bus_wdata[2:0];

        if (ack_stb && ready) begin
            if (grant) begin
                ack_one  = NUM_IN'(1) << req_idx;
                st_d.vec = st_q.base + 8'(req_idx);
            end else begin
                st_d.vec = st_q.base + LOW_OFS;
            end
        end

        st_d.irr = ((st_q.irr & ~ack_one) | rise) & irq_in;
        st_d.isr = (st_q.isr & ~eoi_one) | (st_q.aeoi ? '0 : ack_one);

        if (cmd_wr && ready) begin
            if (bus_wdata == CMD_SEL_REQ) st_d.rd_svc = 1'b0;
            if (bus_wdata == CMD_SEL_SVC) st_d.rd_svc = 1'b1;
        end

        if (dat_wr) begin
            unique case (st_q.phase)
                PH_BASE: begin
                    st_d.base  = bus_wdata;
                    st_d.phase = PH_CASC;
                end
                PH_CASC: begin
                    st_d.casc  = bus_wdata;
                    st_d.phase = PH_MODE;
                end
                PH_MODE: begin
                    st_d.aeoi  = bus_wdata[MODE_AUTO_B];
                    st_d.phase = PH_RUN;
                end
                PH_RUN:  st_d.mask = bus_wdata[NUM_IN-1:0];
                default: ;
            endcase
        end

        if (cmd_wr && (bus_wdata == CMD_SETUP)) begin
            st_d.phase  = PH_BASE;
            st_d.irr    = '0;
            st_d.isr    = '0;
            st_d.mask   = '1;
            st_d.rd_svc = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.phase  <= PH_IDLE;
            st_q.mask   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_out   = grant;
    assign vec_out   = st_q.vec;
    assign casc_word = st_q.casc;
    assign bus_rdata = bus_sel ? 8'(st_q.mask)
                               : (st_q.rd_svc ? 8'(st_q.isr) : 8'(st_q.irr));

    logic [NUM_IN-1:0] irr_w, isr_w, mask_w;
    logic [7:0]        base_w;
    logic              aeoi_w;
    assign irr_w  = st_q.irr;
    assign isr_w  = st_q.isr;
    assign mask_w = st_q.mask;
    assign base_w = st_q.base;
    assign aeoi_w = st_q.aeoi;

endmodule

// File: rtl/vic8_ctrl_chk.sv
module vic8_ctrl_chk #(
    parameter int NUM_IN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              ack_stb,
    input logic              int_out,
    input logic [NUM_IN-1:0] irq_in,
    input logic [7:0]        vec_out,
    input logic [7:0]        base_w,
    input logic              aeoi_w,
    input logic [NUM_IN-1:0] irr_w,
    input logic [NUM_IN-1:0] isr_w,
    input logic [NUM_IN-1:0] mask_w
);
    p_quiet_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out);

    p_need_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr_w & ~mask_w) != '0));

    p_svc_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ack_stb && int_out && !aeoi_w && !bus_wr)
        |=> ($countones(isr_w) == $past($countones(isr_w)) + 1));

    p_vec_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ack_stb && !bus_wr) |=> (8'(vec_out - base_w) < 8'(NUM_IN)));

    p_eoi_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bus_wr && !bus_sel && (bus_wdata[7:3] == 5'b01100) && !ack_stb)
        |=> (isr_w == ($past(isr_w) & ~(NUM_IN'(1) << $past(bus_wdata[2:0])))));

    p_auto_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && aeoi_w && ack_stb && !bus_wr) |=> $stable(isr_w));

    p_spur_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ack_stb && !int_out && !bus_wr)
        |=> ((vec_out == 8'(base_w + 8'(NUM_IN - 1))) && $stable(isr_w)));

    p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((irr_w & ~$past(irq_in)) == '0));

endmodule

bind vic8_ctrl vic8_ctrl_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .ack_stb  (ack_stb),
    .int_out  (int_out),
    .irq_in   (irq_in),
    .vec_out  (vec_out),
    .base_w   (base_w),
    .aeoi_w   (aeoi_w),
    .irr_w    (irr_w),
    .isr_w    (isr_w),
    .mask_w   (mask_w)
);

// File: tb/vic8_ctrl_test.sv
module vic8_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       int_out;
    logic       ack_stb = 1'b0;
    logic [7:0] vec_out;
    logic [7:0] casc_word;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vic8_ctrl #(.NUM_IN(8)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_in   (irq_in),
        .int_out  (int_out),
        .ack_stb  (ack_stb),
        .vec_out  (vec_out),
        .casc_word(casc_word)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        bus_sel   = sel;
        bus_wr    = 1'b1;
        bus_wdata = d;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        bus_sel = sel;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack(output logic [7:0] v);
        ack_stb = 1'b1;
        tick();
        ack_stb = 1'b0;
        v = vec_out;
    endtask

    task automatic setup(input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
        wr(1'b0, 8'h11);
        wr(1'b1, b);
        wr(1'b1, c);
        wr(1'b1, m);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b0, d); chk("R1 request read", d, 8'h00);
        rd(1'b1, d); chk("R1 mask read", d, 8'hFF);
        chk("R1 int_out", {7'b0, int_out}, 8'h00);
        chk("R1 casc_word", casc_word, 8'h00);
    endtask

    task automatic t_unprogrammed();
        logic [7:0] d;
        wr(1'b1, 8'h00);
        rd(1'b1, d); chk("R2 early data write ignored", d, 8'hFF);
        irq_in[0] = 1'b1; tick();
        chk("R2 no interrupt before setup", {7'b0, int_out}, 8'h00);
        irq_in[0] = 1'b0; tick();
    endtask

    task automatic t_setup();
        logic [7:0] d;
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h20);
        rd(1'b1, d); chk("R2 base word not a mask", d, 8'hFF);
        wr(1'b1, 8'h04);
        rd(1'b1, d); chk("R2 cascade word not a mask", d, 8'hFF);
        wr(1'b1, 8'h00);
        chk("R11 cascade shown", casc_word, 8'h04);
        wr(1'b1, 8'h00);
        rd(1'b1, d); chk("R5 mask readback", d, 8'h00);
    endtask

    task automatic t_vector();
        logic [7:0] d;
        irq_in[3] = 1'b1; tick();
        chk("R3 int raised", {7'b0, int_out}, 8'h01);
        rd(1'b0, d); chk("R6 request read default", d, 8'h08);
        ack(d); chk("R3 vector for input 3", d, 8'h23);
        rd(1'b0, d); chk("R3 request cleared", d, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R6 in-service read", d, 8'h08);
        irq_in[3] = 1'b0; tick();
        rd(1'b0, d); chk("R6 select held", d, 8'h08);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        irq_in[5] = 1'b1; tick();
        chk("R4 lower request blocked", {7'b0, int_out}, 8'h00);
        irq_in[1] = 1'b1; tick();
        chk("R4 higher request passes", {7'b0, int_out}, 8'h01);
        ack(d); chk("R4 vector input 1", d, 8'h21);
        rd(1'b0, d); chk("R3 nested in-service", d, 8'h0A);
        wr(1'b0, 8'h61);
        rd(1'b0, d); chk("R7 only bit 1 cleared", d, 8'h08);
        chk("R4 still blocked by 3", {7'b0, int_out}, 8'h00);
        wr(1'b0, 8'h63);
        chk("R7 unblocked", {7'b0, int_out}, 8'h01);
        ack(d); chk("R4 vector input 5", d, 8'h25);
        wr(1'b0, 8'h65);
        irq_in = 8'h00; tick();
        irq_in = 8'h44; tick();
        ack(d); chk("R4 input 2 beats 6", d, 8'h22);
        wr(1'b0, 8'h62);
        ack(d); chk("R4 input 6 next", d, 8'h26);
        wr(1'b0, 8'h66);
        irq_in = 8'h00; tick();
        rd(1'b0, d); chk("R7 all service ended", d, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        wr(1'b0, 8'h0A);
        wr(1'b1, 8'h10);
        irq_in[4] = 1'b1; tick();
        chk("R5 masked input silent", {7'b0, int_out}, 8'h00);
        rd(1'b0, d); chk("R5 masked request latched", d, 8'h10);
        wr(1'b1, 8'h00);
        chk("R5 unmask raises int", {7'b0, int_out}, 8'h01);
        ack(d); chk("R5 vector input 4", d, 8'h24);
        wr(1'b0, 8'h64);
        irq_in[4] = 1'b0; tick();
    endtask

    task automatic t_spurious();
        logic [7:0] d;
        wr(1'b1, 8'h80);
        irq_in[6] = 1'b1; tick();
        chk("R10 request pending", {7'b0, int_out}, 8'h01);
        irq_in[6] = 1'b0; tick();
        chk("R10 request dropped", {7'b0, int_out}, 8'h00);
        ack(d); chk("R9 vanished request vector", d, 8'h27);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R9 nothing in service", d, 8'h00);
        wr(1'b1, 8'hFF);
        irq_in[0] = 1'b1; tick();
        ack(d); chk("R9 all masked vector", d, 8'h27);
        rd(1'b0, d); chk("R9 still nothing in service", d, 8'h00);
        irq_in[0] = 1'b0; tick();
        wr(1'b1, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        irq_in[4] = 1'b1; tick();
        ack(d); chk("R12 first vector", d, 8'h24);
        irq_in[1] = 1'b1; tick();
        bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = 8'h64; ack_stb = 1'b1;
        tick();
        bus_wr = 1'b0; ack_stb = 1'b0;
        chk("R12 vector with end cmd", vec_out, 8'h21);
        rd(1'b0, d); chk("R12 other bit cleared new set", d, 8'h02);
        wr(1'b0, 8'h61);
        irq_in = 8'h00; tick();
        irq_in[5] = 1'b1; tick();
        bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = 8'h65; ack_stb = 1'b1;
        tick();
        bus_wr = 1'b0; ack_stb = 1'b0;
        rd(1'b0, d); chk("R12 same input stays set", d, 8'h20);
        wr(1'b0, 8'h65);
        irq_in = 8'h00; tick();
    endtask

    task automatic t_auto();
        logic [7:0] d;
        setup(8'h40, 8'h02, 8'h02);
        rd(1'b1, d); chk("R2 setup masks all", d, 8'hFF);
        rd(1'b0, d); chk("R2 setup selects request read", d, 8'h00);
        chk("R11 new cascade word", casc_word, 8'h02);
        wr(1'b1, 8'h00);
        irq_in[2] = 1'b1; tick();
        ack(d); chk("R8 auto vector", d, 8'h42);
        rd(1'b0, d); chk("R10 held input no new request", d, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R8 no service bit", d, 8'h00);
        irq_in[5] = 1'b1; tick();
        chk("R8 lower input not blocked", {7'b0, int_out}, 8'h01);
        ack(d); chk("R8 second auto vector", d, 8'h45);
        irq_in = 8'h00; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_unprogrammed();
        t_setup();
        t_vector();
        t_priority();
        t_mask();
        t_spurious();
        t_same_cycle();
        t_auto();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule